// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives one whole NAND flash operation on the raw 8-bit flash bus from a small set of registers. Software fills in the address words, the transfer length and an optional follow-up opcode, and then writes a single control word that names the first opcode, the data direction and how many address bytes to send. The engine takes it from there. It issues the first command with CLE high and the address bytes with ALE high. It moves data in or out, issues the follow-up opcode if one is enabled, and waits out the write-to-busy delay. It then watches the ready/busy line before it reads data or declares the operation finished.

Read bytes leave on a valid-only byte sink, sampled at the end of each read-strobe low phase. Write bytes come from a show-ahead byte source: the engine puts the presented byte on the bus and pulses a take signal when that byte's cycle ends. A sticky completion bit and a mask produce a single interrupt line. A busy flag tells software that start writes are currently ignored.

Registers are addressed by a 3-bit word index: 0 control, 1 follow-up opcode, 2 status, 3 interrupt mask, 4 length, 5 low address, 6 high address.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write to index 0 with bit 31 set starts an operation when the engine is idle. The first bus cycle sends bits 7:0 of that word with CLE high and ALE low.
- R2: When bit 30 of the control word is set, the engine sends (bits 29:27)+1 address bytes with ALE high, 1 to 5 of them. The bytes go out in this order: index 5 bits 7:0, index 5 bits 15:8, index 6 bits 7:0, index 6 bits 15:8, index 6 bits 23:16.
- R3: Control bit 26 selects a read data phase, and bit 25 a write data phase when bit 26 is clear. The phase moves exactly the number of bytes held in index 4. With neither bit set, or with a length of 0, there is no data phase. Write bytes are taken from the source in order, one per take pulse.
- R4: When bit 8 of index 1 is set, its bits 7:0 are sent as a second command byte with CLE high. For a read it follows the address phase; otherwise it follows the write data phase.
- R5: After the last command byte, the engine lets at least T_WB clock cycles pass before it samples R/B#. It then waits for R/B# to be high before it starts a read data phase that follows a second opcode, or before it signals completion. A read with no second opcode starts its data phase right after the address phase.
- R6: CE# is low for the whole operation and high when idle. Each byte cycle holds WE# (or RE#) low for T_LO clocks and then high for T_HI clocks, with T_LO=2 and T_HI=2 by default. CLE and ALE are never high together.
- R7: Status bit 31 (index 2) sets when an operation completes. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: The irq output is high exactly when some status bit is set and the matching bit in index 3 is set.
- R9: Status bit 0 reads 1 while an operation runs. A start write during that time is ignored and sends nothing to the flash.
- R10: Each read byte appears on rd_data with a one-cycle rd_valid pulse, taken from the flash bus at the last clock of the RE# low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Masked completion interrupt |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data bus, outbound value |
| nf_dq_oe | output | 1 | Flash data bus drive enable |
| nf_dq_i | input | 8 | Flash data bus, inbound value |
| nf_rb_n | input | 1 | Flash ready (high) / busy (low) |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| wr_data | input | 8 | Next write byte from the source |
| wr_take | output | 1 | Write byte consumed pulse |

## Verification
The in-RTL assertions check, on every cycle, the bus rules that must always hold. CLE and ALE are never high together, WE# and RE# are never low together, a read byte is only emitted under an active RE# with CE# low, and a start is only accepted from idle. They also check that the ready line is never sampled less than T_WB cycles after a command byte, and that a completion always leaves the sticky status bit set. Only the bench scenarios can show the content and order of the bus traffic for the different control-word shapes. The same holds for the strobe widths, for the gating of data and completion by a flash that goes busy late, for ignored starts, and for the write-one-to-clear and mask behaviour.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
    localparam int LEN_W = 16;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMD2  = 3'd1;
    localparam logic [2:0] A_STAT  = 3'd2;
    localparam logic [2:0] A_MASK  = 3'd3;
    localparam logic [2:0] A_LEN   = 3'd4;
    localparam logic [2:0] A_ADDR1 = 3'd5;
    localparam logic [2:0] A_ADDR2 = 3'd6;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2,
        S_TWB, S_WAITRB, S_RDATA, S_DONE
    } nfs_state_e;

    typedef struct packed {
        logic [7:0]       opc;
        logic [7:0]       opc2;
        logic             opc2_en;
        logic             rd;
        logic             wr;
        logic             addr_en;
        logic [2:0]       naddr_m1;
        logic [39:0]      addr;
        logic [LEN_W-1:0] len;
    } nfs_job_t;
endpackage

// File: rtl/nfs_regs.sv
module nfs_regs
    import nfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy,
    input  logic        done,
    output logic        start,
    output nfs_job_t    job,
    output logic        irq
);
    typedef struct packed {
        logic [8:0]       cmd2;
        logic             stat_done;
        logic [31:0]      mask;
        logic [LEN_W-1:0] len;
        logic [15:0]      addr1;
        logic [23:0]      addr2;
    } regs_t;

    regs_t q, d;
    logic [31:0] stat_w;

    always_comb begin
        d = q;
        if (reg_we) begin
            unique case (reg_addr)
                A_CMD2:  d.cmd2  = reg_wdata[8:0];
                A_STAT:  if (reg_wdata[31]) d.stat_done = 1'b0;
                A_MASK:  d.mask  = reg_wdata;
                A_LEN:   d.len   = reg_wdata[LEN_W-1:0];
                A_ADDR1: d.addr1 = reg_wdata[15:0];
                A_ADDR2: d.addr2 = reg_wdata[23:0];
                default: ;
            endcase
        end
        if (done) d.stat_done = 1'b1;

        start = reg_we && (reg_addr == A_CTRL) && reg_wdata[31] && !busy;

        job.opc      = reg_wdata[7:0];
        job.rd       = reg_wdata[26];
        job.wr       = reg_wdata[25];
        job.addr_en  = reg_wdata[30];
        job.naddr_m1 = reg_wdata[29:27];
        job.opc2     = q.cmd2[7:0];
        job.opc2_en  = q.cmd2[8];
        job.addr     = {q.addr2, q.addr1};
        job.len      = q.len;

        stat_w = {q.stat_done, 30'd0, busy};
        irq    = |(stat_w & q.mask);

        unique case (reg_addr)
            A_CMD2:  reg_rdata = {23'd0, q.cmd2};
            A_STAT:  reg_rdata = stat_w;
            A_MASK:  reg_rdata = q.mask;
            A_LEN:   reg_rdata = {{(32-LEN_W){1'b0}}, q.len};
            A_ADDR1: reg_rdata = {16'd0, q.addr1};
            A_ADDR2: reg_rdata = {8'd0, q.addr2};
            default: reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: a completion leaves the sticky bit set on the next cycle
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> q.stat_done);
    // R8: interrupt line needs the completion bit or busy under the mask
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((q.stat_done && q.mask[31]) || (busy && q.mask[0])));
endmodule

// File: rtl/nfs_engine.sv
module nfs_engine
    import nfs_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 2,
    parameter int T_WB = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  nfs_job_t   job_in,
    output logic       busy,
    output logic       done,
    output logic       nf_ce_n,
    output logic       nf_cle,
    output logic       nf_ale,
    output logic       nf_we_n,
    output logic       nf_re_n,
    output logic [7:0] nf_dq_o,
    output logic       nf_dq_oe,
    input  logic [7:0] nf_dq_i,
    input  logic       nf_rb_n,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    input  logic [7:0] wr_data,
    output logic       wr_take
);
    localparam int CNT_MAX = (T_WB > T_LO) ? ((T_WB > T_HI) ? T_WB : T_HI)
                                           : ((T_LO > T_HI) ? T_LO : T_HI);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        nfs_state_e       st;
        logic             lo;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] idx;
        nfs_job_t         job;
        logic [1:0]       rb_s;
    } eng_t;

    eng_t q, d;

    function automatic eng_t jump(eng_t s, nfs_state_e t);
        s.st  = t;
        s.idx = '0;
        s.cnt = '0;
        s.lo  = 1'b1;
        return s;
    endfunction

    logic has_rd, has_wr, rb_hi, last_lo, last_hi, bus_st, wr_st;
    nfs_state_e post_addr, after_wr;

    always_comb begin
        has_rd  = q.job.rd && (q.job.len != '0);
        has_wr  = !q.job.rd && q.job.wr && (q.job.len != '0);
        rb_hi   = q.rb_s[1];
        last_lo = q.lo && (q.cnt == CNT_W'(T_LO - 1));
        last_hi = !q.lo && (q.cnt == CNT_W'(T_HI - 1));
        wr_st   = (q.st == S_CMD1) || (q.st == S_ADDR) || (q.st == S_WDATA) || (q.st == S_CMD2);
        bus_st  = wr_st || (q.st == S_RDATA);

        after_wr  = q.job.opc2_en ? S_CMD2 : S_TWB;
        post_addr = has_rd ? (q.job.opc2_en ? S_CMD2 : S_RDATA)
                  : has_wr ? S_WDATA : after_wr;

        d      = q;
        d.rb_s = {q.rb_s[0], nf_rb_n};

        if (bus_st) begin
            if (last_lo) begin
                d.lo  = 1'b0;
                d.cnt = '0;
            end else if (last_hi) begin
                d.lo  = 1'b1;
                d.cnt = '0;
                unique case (q.st)
                    S_CMD1:  d = jump(d, q.job.addr_en ? S_ADDR : post_addr);
                    S_ADDR:  if (q.idx[2:0] == q.job.naddr_m1) d = jump(d, post_addr);
                             else d.idx = q.idx + 1'b1;
                    S_WDATA: if (q.idx == q.job.len - 1'b1) d = jump(d, after_wr);
                             else d.idx = q.idx + 1'b1;
                    S_CMD2:  d = jump(d, S_TWB);
                    default: if (q.idx == q.job.len - 1'b1) d = jump(d, S_DONE);
                             else d.idx = q.idx + 1'b1;
                endcase
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            unique case (q.st)
                S_IDLE: if (start) begin
                    d     = jump(d, S_CMD1);
                    d.job = job_in;
                end
                S_TWB: if (q.cnt == CNT_W'(T_WB - 1)) d = jump(d, S_WAITRB);
                       else d.cnt = q.cnt + 1'b1;
                S_WAITRB: if (rb_hi) d = jump(d, has_rd ? S_RDATA : S_DONE);
                default: d = jump(d, S_IDLE);
            endcase
        end

        busy     = q.st != S_IDLE;
        done     = q.st == S_DONE;
        nf_ce_n  = (q.st == S_IDLE) || (q.st == S_DONE);
        nf_cle   = (q.st == S_CMD1) || (q.st == S_CMD2);
        nf_ale   = q.st == S_ADDR;
        nf_we_n  = !(q.lo && wr_st);
        nf_re_n  = !(q.lo && (q.st == S_RDATA));
        nf_dq_oe = wr_st;
        unique case (q.st)
            S_CMD1:  nf_dq_o = q.job.opc;
            S_CMD2:  nf_dq_o = q.job.opc2;
            S_ADDR:  nf_dq_o = 8'(q.job.addr >> {q.idx[2:0], 3'b000});
            S_WDATA: nf_dq_o = wr_data;
            default: nf_dq_o = 8'h00;
        endcase
        rd_valid = (q.st == S_RDATA) && last_lo;
        rd_data  = nf_dq_i;
        wr_take  = (q.st == S_WDATA) && last_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.lo   <= 1'b1;
            q.rb_s <= 2'b11;
        end else begin
            q <= d;
        end
    end

    // Cycles since the last command byte, for the write-to-busy check
    logic [CNT_W:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap_q <= '0;
        else if (nf_cle)       gap_q <= '0;
        else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end

    // R5: R/B# is never sampled earlier than T_WB cycles after a command byte
    a_r5_twb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WAITRB) |-> (gap_q >= (CNT_W+1)'(T_WB)));
    // R5: a read phase after the ready wait only starts on a ready line
    a_r5_ready_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RDATA && $past(q.st) == S_WAITRB) |-> $past(rb_hi));
    // R6: command and address latches are exclusive
    a_r6_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    // R6: write and read strobes never overlap
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));
    // R10: a read byte only comes under an active read strobe
    a_r10_rd_under_re: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!nf_re_n && !nf_ce_n));
    // R9: starts are accepted only from idle
    a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == S_IDLE));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nfs_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 2,
    parameter int T_WB = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        nf_ce_n,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_o,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_i,
    input  logic        nf_rb_n,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    input  logic [7:0]  wr_data,
    output logic        wr_take
);
    logic     busy, done, start;
    nfs_job_t job;

    nfs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .done(done), .start(start), .job(job), .irq(irq)
    );

    nfs_engine #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .job_in(job),
        .busy(busy), .done(done), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i),
        .nf_rb_n(nf_rb_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_data(wr_data), .wr_take(wr_take)
    );
endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
    localparam int T_LO = 2;
    localparam int T_HI = 2;
    localparam int T_WB = 25;
    localparam int BUSY_DLY = 20;
    localparam int BUSY_LEN = 80;
    localparam logic [7:0] RD_BASE = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_o, nf_dq_i, rd_data, wr_data;
    logic        nf_rb_n, rd_valid, wr_take;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    nand_cmd_seq #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB)) u_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
        .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_data(wr_data),
        .wr_take(wr_take)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int busy_dly = 0, busy_len = 0, rd_idx = 0;
    logic we_prev_f = 1'b1, re_prev_f = 1'b1;
    assign nf_rb_n = (busy_len == 0);
    assign nf_dq_i = RD_BASE + 8'(rd_idx);

    always @(posedge clk) begin
        we_prev_f <= nf_we_n;
        re_prev_f <= nf_re_n;
        if (busy_dly > 0) begin
            busy_dly <= busy_dly - 1;
            if (busy_dly == 1) busy_len <= BUSY_LEN;
        end else if (busy_len > 0) begin
            busy_len <= busy_len - 1;
        end
        if (!we_prev_f && nf_we_n && nf_cle) begin
            rd_idx <= 0;
            if (nf_dq_o == 8'h30 || nf_dq_o == 8'h10 || nf_dq_o == 8'hFF)
                busy_dly <= BUSY_DLY;
        end else if (!re_prev_f && nf_re_n) begin
            rd_idx <= rd_idx + 1;
        end
    end

    // ---------------- write source ----------------
    int wr_ptr = 0;
    assign wr_data = 8'hC0 + 8'(wr_ptr);
    always @(negedge clk) if (wr_take) wr_ptr <= wr_ptr + 1;

    // ---------------- scoreboard ----------------
    logic [9:0] exp_q[$];
    string      tag_q[$];

    task automatic expect_ev(input logic [1:0] kind, input logic [7:0] b, input string req);
        exp_q.push_back({kind, b});
        tag_q.push_back(req);
    endtask

    task automatic compare_ev(input logic [9:0] got);
        string t;
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL R9: unexpected bus event actual %h expected none", got);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {22'd0, got}, {22'd0, e});
        end
    endtask

    // kinds: 0 command, 1 address, 2 write data, 3 read data
    logic we_prev_m = 1'b1, re_prev_m = 1'b1;
    int   we_run = 0, re_run = 0;
    logic flash_pending;
    assign flash_pending = (busy_dly > 0) || (busy_len > 0);

    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev_m && nf_we_n) begin
                compare_ev({nf_cle ? 2'd0 : (nf_ale ? 2'd1 : 2'd2), nf_dq_o});
                check("R6 we_low_width", we_run, T_LO);
            end
            if (!re_prev_m && nf_re_n) check("R6 re_low_width", re_run, T_LO);
            if (rd_valid) compare_ev({2'd3, rd_data});
            if (!nf_re_n && !nf_rb_n) begin
                compared++;
                mismatched++;
                $display("FAIL R5: RE# low while busy actual 0 expected 1");
            end
            if (irq && $past(!irq) && flash_pending) begin
                compared++;
                mismatched++;
                $display("FAIL R5: completion during busy actual 1 expected 0");
            end
            if ((!nf_we_n || !nf_re_n) && nf_ce_n) begin
                compared++;
                mismatched++;
                $display("FAIL R6: strobe with CE# high actual 1 expected 0");
            end
        end
        we_run    <= nf_we_n ? 0 : we_run + 1;
        re_run    <= nf_re_n ? 0 : re_run + 1;
        we_prev_m <= nf_we_n;
        re_prev_m <= nf_re_n;
    end

    // ---------------- register access ----------------
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n = 0;
        do begin
            rd_reg(3'd2, v);
            n++;
        end while (!v[31] && n < 5000);
    endtask

    // Driver: pushes the expected traffic, programs the block, waits, checks
    task automatic run_txn(input logic [7:0] opc, input logic aen, input int naddr,
                           input logic [15:0] a1, input logic [23:0] a2,
                           input logic rd, input logic wr, input int len,
                           input logic c2en, input logic [7:0] c2, input string name);
        logic [39:0] ab = {a2, a1};
        logic [31:0] v;
        wr_ptr = 0;
        expect_ev(2'd0, opc, "R1");
        if (aen) for (int i = 0; i < naddr; i++) expect_ev(2'd1, ab[8*i +: 8], "R2");
        if (rd && len != 0) begin
            if (c2en) expect_ev(2'd0, c2, "R4");
            for (int i = 0; i < len; i++) expect_ev(2'd3, RD_BASE + 8'(i), "R10");
        end else begin
            if (wr && len != 0) for (int i = 0; i < len; i++) expect_ev(2'd2, 8'hC0 + 8'(i), "R3");
            if (c2en) expect_ev(2'd0, c2, "R4");
        end
        wr_reg(3'd4, 32'(len));
        wr_reg(3'd5, {16'd0, a1});
        wr_reg(3'd6, {8'd0, a2});
        wr_reg(3'd1, {23'd0, c2en, c2});
        wr_reg(3'd0, {1'b1, aen, 3'(naddr - 1), rd, wr, 17'd0, opc});
        wait_done();
        repeat (4) @(negedge clk);
        check({"R3 queue drained ", name}, exp_q.size(), 0);
        check({"R6 CE# idle ", name}, {31'd0, nf_ce_n}, 1);
        rd_reg(3'd2, v);
        check({"R7 status set ", name}, {31'd0, v[31]}, 1);
        wr_reg(3'd2, 32'h8000_0000);
        rd_reg(3'd2, v);
        check({"R7 status cleared ", name}, v, 32'd0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // reset state
        check("R6 reset CE#", {31'd0, nf_ce_n}, 1);
        check("R8 reset irq", {31'd0, irq}, 0);
        rd_reg(3'd2, v);
        check("R9 reset busy", v, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wr_reg(3'd3, 32'h8000_0000);

        // R2 R4 R5 R10: page read with five address bytes and confirm opcode
        run_txn(8'h00, 1'b1, 5, 16'h3412, 24'h786756, 1'b1, 1'b0, 6, 1'b1, 8'h30, "page read");
        // R3 R4 R5: program with four address bytes
        run_txn(8'h80, 1'b1, 4, 16'hBBAA, 24'h00DDCC, 1'b0, 1'b1, 5, 1'b1, 8'h10, "program");
        // R10: identify read, one address byte, no second opcode
        run_txn(8'h90, 1'b1, 1, 16'h0000, 24'h000000, 1'b1, 1'b0, 3, 1'b0, 8'h00, "id read");
        // R3: read bit with length 0 gives no data phase
        run_txn(8'h70, 1'b0, 1, 16'h0000, 24'h000000, 1'b1, 1'b0, 0, 1'b0, 8'h00, "zero len");
        // R3: write bit with no second opcode, two address bytes
        run_txn(8'h85, 1'b1, 2, 16'h2211, 24'h000000, 1'b0, 1'b1, 2, 1'b0, 8'h00, "col write");

        // R9: busy flag and ignored start while a reset command is pending
        wr_ptr = 0;
        expect_ev(2'd0, 8'hFF, "R1");
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd0, 32'h8000_00FF);
        repeat (30) @(negedge clk);
        rd_reg(3'd2, v);
        check("R9 busy flag", {31'd0, v[0]}, 1);
        wr_reg(3'd0, 32'h8400_0070);
        wait_done();
        repeat (40) @(negedge clk);
        check("R9 ignored start queue", exp_q.size(), 0);
        check("R9 idle after ignored start", {31'd0, nf_ce_n}, 1);

        // R7 R8: write-one-to-clear and mask gating
        check("R8 irq with mask", {31'd0, irq}, 1);
        wr_reg(3'd2, 32'h0000_0000);
        rd_reg(3'd2, v);
        check("R7 write zero keeps", {31'd0, v[31]}, 1);
        wr_reg(3'd3, 32'h0000_0000);
        @(negedge clk);
        check("R8 irq masked", {31'd0, irq}, 0);
        wr_reg(3'd2, 32'h8000_0000);
        rd_reg(3'd2, v);
        check("R7 cleared", v, 32'd0);
        wr_reg(3'd3, 32'h8000_0000);
        @(negedge clk);
        check("R8 irq after clear", {31'd0, irq}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule